// File: doc/BRIEF.md
# Wait-Stated 16-Bit Bus Target

This block answers a host that talks over an asynchronous strobe bus: an active-low chip select, a 17-bit byte address, two active-low write strobes (one per data byte), two active-low read strobes and a 16-bit data bus. When a strobe falls inside the block's address window, the block drives its wait line low. It carries out the access on an internal word store whose latency in bus clocks is a parameter. It then drives the wait line high on a clock edge, and floats it again once the host lifts the strobe. For reads, the returned word is on the data outputs by the edge that raises the wait line.

The pads are outside the block. Each three-state output comes out as a value plus an output enable. The chip select and both strobe groups pass through a two-flop synchronizer, and every decision is taken on their synchronized edges. If the host lifts a strobe before the block has released the wait line, the access is dropped without touching the store, and a saturating error count goes up by one.

Top module: `strobe_wait_target`

## Requirements
- R1: After a synchronous reset the wait enable and the data enable are both 0 and the error count is 0.
- R2: A falling read or write strobe with chip select low and an address inside the window turns the wait enable on, driving the wait value 0. This happens on the third rising clock edge after the strobe falls: two synchronizer stages plus one decision register.
- R3: The wait value goes to 1 exactly LAT rising edges after the wait enable came on (LAT >= 1). It stays driven at 1 until the strobe is lifted.
- R4: For a read, the data enable comes on together with the wait enable. On the edge that drives the wait value to 1, the data outputs carry the stored word, and they stay stable while the wait line is high. The window holds byte addresses whose bits 16..9 equal those of WIN_BASE. The word index is address bits 8..1, so bit 0 is ignored.
- R5: The third rising edge after the host lifts all strobes turns both the wait enable and the data enable off.
- R6: A write stores data bits 7..0 only when the low write strobe is low, and bits 15..8 only when the high write strobe is low. The other byte of the word is unchanged.
- R7: With chip select high, or with an address outside the window, a strobe gets no response: the enables stay off and the store is not written.
- R8: If the strobe is lifted before the wait value has gone to 1, the store is not written, both enables turn off, and the error count goes up by one, holding at its maximum.
- R9: A read through either read strobe alone returns the full 16-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_addr | input | 17 | Byte address |
| bus_wr_lo_n | input | 1 | Write strobe for bits 7..0, active low |
| bus_wr_hi_n | input | 1 | Write strobe for bits 15..8, active low |
| bus_rd_lo_n | input | 1 | Read strobe, low byte, active low |
| bus_rd_hi_n | input | 1 | Read strobe, high byte, active low |
| bus_din | input | 16 | Data arriving from the pads |
| bus_dout | output | 16 | Read data toward the pads |
| bus_dout_oe | output | 1 | Output enable of the data pads |
| bus_stall_n | output | 1 | Wait line value (0 = wait) |
| bus_stall_oe | output | 1 | Output enable of the wait line |
| err_count | output | ERR_W | Count of abandoned accesses, saturating |

## Verification
The bench counts edges from each strobe fall, so a synchronizer one stage short or long moves the wait enable off the third edge and is caught. A latency counter off by one raises the wait line on the wrong edge. A read path that takes the store output one cycle late returns the word of the previous access on the edge that raises the wait line. Single-lane writes are read back to catch a design that ignores the byte selects. The other corner cases are writes with chip select high or outside the window, strobes lifted before completion (a design that wrote anyway, or did not count, shows a changed word or a stale error count), and reads through one strobe and through an odd byte address.

// File: rtl/tgt_pkg.sv
package tgt_pkg;

  localparam int BUS_DW = 16;
  localparam int LANES  = BUS_DW / 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_READY = 2'd2
  } tgt_state_e;

  // synchronized control bits, active high
  localparam int CTL_W  = 3;
  localparam int CTL_CS = 2;
  localparam int CTL_RD = 1;
  localparam int CTL_WR = 0;

endpackage

// File: rtl/tgt_sync.sv
module tgt_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_sync,
  output logic [W-1:0] q_prev
);

  logic [STAGES:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d_in;
      for (int i = 1; i <= STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign q_sync = chain[STAGES-1];
  assign q_prev = chain[STAGES];

endmodule

// File: rtl/tgt_ram.sv
module tgt_ram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            we,
  input  logic [DW/8-1:0] wbe,
  input  logic [AW-1:0]   waddr,
  input  logic [DW-1:0]   wdata,
  input  logic [AW-1:0]   raddr,
  output logic [DW-1:0]   rdata
);

  localparam int NB    = DW / 8;
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [7:0] mem_l [DEPTH];
    logic [7:0] q_l;

    always_ff @(posedge clk) begin
      if (we && wbe[g]) begin
        mem_l[waddr] <= wdata[g*8 +: 8];
      end
      q_l <= mem_l[raddr];
    end

    assign rdata[g*8 +: 8] = q_l;
  end

endmodule

// File: rtl/tgt_ctrl.sv
module tgt_ctrl
  import tgt_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LAT   = 4,
  parameter int ERR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              acc_s,
  input  logic              acc_prev,
  input  logic              wr_s,
  input  logic              hit,
  input  logic [AW-1:0]     bus_waddr,
  input  logic [LANES-1:0]  bus_lanes,
  input  logic [BUS_DW-1:0] bus_din,
  input  logic [BUS_DW-1:0] ram_q,
  output logic [AW-1:0]     ram_raddr,
  output logic              ram_we,
  output logic [LANES-1:0]  ram_wbe,
  output logic [AW-1:0]     ram_waddr,
  output logic [BUS_DW-1:0] ram_wdata,
  output logic              stall_n,
  output logic              stall_oe,
  output logic [BUS_DW-1:0] dout,
  output logic              dout_oe,
  output logic [ERR_W-1:0]  err_cnt
);

  localparam int CW = $clog2(LAT + 1);

  tgt_state_e          state;
  logic [CW-1:0]       cnt;
  logic [AW-1:0]       addr_q;
  logic [LANES-1:0]    wbe_q;
  logic                is_wr_q;
  logic                start;
  logic                last;

  assign start = (state == ST_IDLE) && acc_s && !acc_prev && cs_s && hit;
  assign last  = (state == ST_BUSY) && acc_s && (cnt == CW'(1));

  // address mux lets a latency of one still see a registered read
  assign ram_raddr = (state == ST_IDLE) ? bus_waddr : addr_q;
  assign ram_we    = last && is_wr_q;
  assign ram_wbe   = wbe_q;
  assign ram_waddr = addr_q;
  assign ram_wdata = bus_din;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      addr_q   <= '0;
      wbe_q    <= '0;
      is_wr_q  <= 1'b0;
      stall_n  <= 1'b1;
      stall_oe <= 1'b0;
      dout     <= '0;
      dout_oe  <= 1'b0;
      err_cnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_BUSY;
            cnt      <= CW'(LAT);
            addr_q   <= bus_waddr;
            wbe_q    <= bus_lanes;
            is_wr_q  <= wr_s;
            stall_oe <= 1'b1;
            stall_n  <= 1'b0;
            dout_oe  <= !wr_s;
          end
        end
        ST_BUSY: begin
          if (!acc_s) begin
            state    <= ST_IDLE;
            stall_oe <= 1'b0;
            stall_n  <= 1'b1;
            dout_oe  <= 1'b0;
            if (err_cnt != '1) begin
              err_cnt <= err_cnt + 1'b1;
            end
          end else if (last) begin
            state   <= ST_READY;
            stall_n <= 1'b1;
            if (!is_wr_q) begin
              dout <= ram_q;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_READY: begin
          if (!acc_s) begin
            state    <= ST_IDLE;
            stall_oe <= 1'b0;
            dout_oe  <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/strobe_wait_target.sv
module strobe_wait_target
  import tgt_pkg::*;
#(
  parameter int          BUS_AW   = 17,
  parameter int          WORD_AW  = 8,
  parameter logic [16:0] WIN_BASE = 17'h1_0000,
  parameter int          LAT      = 4,
  parameter int          ERR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr_lo_n,
  input  logic              bus_wr_hi_n,
  input  logic              bus_rd_lo_n,
  input  logic              bus_rd_hi_n,
  input  logic [BUS_DW-1:0] bus_din,
  output logic [BUS_DW-1:0] bus_dout,
  output logic              bus_dout_oe,
  output logic              bus_stall_n,
  output logic              bus_stall_oe,
  output logic [ERR_W-1:0]  err_count
);

  localparam int HI_LSB = WORD_AW + 1;

  logic [CTL_W-1:0]   ctl_raw;
  logic [CTL_W-1:0]   ctl_s;
  logic [CTL_W-1:0]   ctl_p;
  logic               hit;
  logic [WORD_AW-1:0] waddr_bus;
  logic [LANES-1:0]   lanes_bus;
  logic [BUS_DW-1:0]  ram_q;
  logic [WORD_AW-1:0] ram_raddr;
  logic [WORD_AW-1:0] ram_waddr;
  logic [BUS_DW-1:0]  ram_wdata;
  logic [LANES-1:0]   ram_wbe;
  logic               ram_we;
  logic               unused_ok;

  assign ctl_raw[CTL_CS] = !bus_cs_n;
  assign ctl_raw[CTL_RD] = !(bus_rd_lo_n && bus_rd_hi_n);
  assign ctl_raw[CTL_WR] = !(bus_wr_lo_n && bus_wr_hi_n);

  assign hit       = (bus_addr[BUS_AW-1:HI_LSB] == WIN_BASE[BUS_AW-1:HI_LSB]);
  assign waddr_bus = bus_addr[WORD_AW:1];
  assign lanes_bus = {!bus_wr_hi_n, !bus_wr_lo_n};
  assign unused_ok = &{1'b0, bus_addr[0], ctl_p[CTL_CS]};

  tgt_sync #(.W(CTL_W), .STAGES(2)) i_sync (
    .clk    (clk),
    .rst    (rst),
    .d_in   (ctl_raw),
    .q_sync (ctl_s),
    .q_prev (ctl_p)
  );

  tgt_ram #(.AW(WORD_AW), .DW(BUS_DW)) i_ram (
    .clk   (clk),
    .we    (ram_we),
    .wbe   (ram_wbe),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_q)
  );

  tgt_ctrl #(.AW(WORD_AW), .LAT(LAT), .ERR_W(ERR_W)) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cs_s      (ctl_s[CTL_CS]),
    .acc_s     (ctl_s[CTL_RD] || ctl_s[CTL_WR]),
    .acc_prev  (ctl_p[CTL_RD] || ctl_p[CTL_WR]),
    .wr_s      (ctl_s[CTL_WR]),
    .hit       (hit),
    .bus_waddr (waddr_bus),
    .bus_lanes (lanes_bus),
    .bus_din   (bus_din),
    .ram_q     (ram_q),
    .ram_raddr (ram_raddr),
    .ram_we    (ram_we),
    .ram_wbe   (ram_wbe),
    .ram_waddr (ram_waddr),
    .ram_wdata (ram_wdata),
    .stall_n   (bus_stall_n),
    .stall_oe  (bus_stall_oe),
    .dout      (bus_dout),
    .dout_oe   (bus_dout_oe),
    .err_cnt   (err_count)
  );

endmodule

// File: rtl/tgt_checker.sv
module tgt_checker #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_cs_n,
  input logic [15:0]      bus_dout,
  input logic             bus_dout_oe,
  input logic             bus_stall_n,
  input logic             bus_stall_oe,
  input logic [ERR_W-1:0] err_count
);

  // R2: the wait line is first driven low
  p_wait_low_first_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_stall_oe) |-> !bus_stall_n);

  // R3: the wait line goes high only while it was already driven
  p_rise_while_driven_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_stall_oe && bus_stall_n && !$past(bus_stall_n)) |-> $past(bus_stall_oe));

  // R4: read data stays put while the wait line is held high
  p_read_data_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_dout_oe && bus_stall_oe && bus_stall_n &&
     $past(bus_stall_oe && bus_stall_n)) |-> $stable(bus_dout));

  // R5: the data enable never outlives the wait enable
  p_dout_inside_wait_r5: assert property (@(posedge clk) disable iff (rst)
    bus_dout_oe |-> bus_stall_oe);

  // R7: a response starts only with chip select low
  p_resp_needs_cs_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_stall_oe) |-> $past(!bus_cs_n));

  // R8: the error count moves by one step at most
  p_err_step_r8: assert property (@(posedge clk) disable iff (rst)
    (err_count != $past(err_count)) |-> (err_count == $past(err_count) + 1'b1));

endmodule

bind strobe_wait_target tgt_checker #(.ERR_W(ERR_W)) i_tgt_checker (
  .clk          (clk),
  .rst          (rst),
  .bus_cs_n     (bus_cs_n),
  .bus_dout     (bus_dout),
  .bus_dout_oe  (bus_dout_oe),
  .bus_stall_n  (bus_stall_n),
  .bus_stall_oe (bus_stall_oe),
  .err_count    (err_count)
);

// File: tb/test_strobe_wait_target.sv
module test_strobe_wait_target;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 4;
  localparam int ERR_W      = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_cs_n = 1'b1;
  logic [16:0] bus_addr = '0;
  logic        wr_lo_n = 1'b1;
  logic        wr_hi_n = 1'b1;
  logic        rd_lo_n = 1'b1;
  logic        rd_hi_n = 1'b1;
  logic [15:0] bus_din = '0;
  logic [15:0] bus_dout;
  logic        bus_dout_oe;
  logic        bus_stall_n;
  logic        bus_stall_oe;
  logic [ERR_W-1:0] err_count;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_wait_target #(.LAT(LAT), .ERR_W(ERR_W)) i_strobe_wait_target (
    .clk          (clk),
    .rst          (rst),
    .bus_cs_n     (bus_cs_n),
    .bus_addr     (bus_addr),
    .bus_wr_lo_n  (wr_lo_n),
    .bus_wr_hi_n  (wr_hi_n),
    .bus_rd_lo_n  (rd_lo_n),
    .bus_rd_hi_n  (rd_hi_n),
    .bus_din      (bus_din),
    .bus_dout     (bus_dout),
    .bus_dout_oe  (bus_dout_oe),
    .bus_stall_n  (bus_stall_n),
    .bus_stall_oe (bus_stall_oe),
    .err_count    (err_count)
  );

  typedef struct packed {
    logic        wr;
    logic [16:0] addr;
    logic [15:0] data;
    logic [1:0]  lanes;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 17'h10000, 16'hA5A5, 2'b11, 16'h0000},
    '{1'b1, 17'h10002, 16'h1234, 2'b11, 16'h0000},
    '{1'b1, 17'h101FE, 16'hFFFF, 2'b11, 16'h0000},
    '{1'b0, 17'h10000, 16'h0000, 2'b11, 16'hA5A5},
    '{1'b0, 17'h10002, 16'h0000, 2'b11, 16'h1234},
    '{1'b1, 17'h10002, 16'hBBCD, 2'b01, 16'h0000},
    '{1'b0, 17'h10002, 16'h0000, 2'b01, 16'h12CD},
    '{1'b1, 17'h10000, 16'h7799, 2'b10, 16'h0000},
    '{1'b0, 17'h10000, 16'h0000, 2'b10, 16'h77A5},
    '{1'b0, 17'h101FE, 16'h0000, 2'b11, 16'hFFFF},
    '{1'b0, 17'h10001, 16'h0000, 2'b01, 16'h77A5}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic release_bus();
    bus_cs_n = 1'b1;
    wr_lo_n  = 1'b1;
    wr_hi_n  = 1'b1;
    rd_lo_n  = 1'b1;
    rd_hi_n  = 1'b1;
  endtask

  // full access: edge counts are taken from the strobe fall
  task automatic run_access(input bit wr, input logic [16:0] a,
                            input logic [15:0] d, input logic [1:0] lanes,
                            input bit sel, output logic [15:0] rdata,
                            output int oe_at, output int hi_at,
                            output bit doe_ok, output bit released);
    oe_at = 0; hi_at = 0; rdata = '0; doe_ok = 1'b0;
    @(negedge clk);
    bus_addr = a;
    bus_din  = d;
    bus_cs_n = !sel;
    if (wr) begin
      wr_lo_n = !lanes[0];
      wr_hi_n = !lanes[1];
    end else begin
      rd_lo_n = !lanes[0];
      rd_hi_n = !lanes[1];
    end
    for (int n = 1; n <= LAT + 8; n++) begin
      @(posedge clk); #1;
      if (oe_at == 0 && bus_stall_oe) oe_at = n;
      if (oe_at != 0 && hi_at == 0 && bus_stall_oe && bus_stall_n) begin
        hi_at  = n;
        rdata  = bus_dout;
        doe_ok = (bus_dout_oe == !wr);
      end
    end
    @(negedge clk);
    release_bus();
    repeat (3) @(posedge clk);
    #1;
    released = !bus_stall_oe && !bus_dout_oe;
  endtask

  // strobe lifted right after the wait line is driven
  task automatic run_abort(input bit wr, input logic [16:0] a,
                           input logic [15:0] d, output bit got_oe,
                           output bit saw_hi, output bit released);
    saw_hi = 1'b0;
    @(negedge clk);
    bus_addr = a;
    bus_din  = d;
    bus_cs_n = 1'b0;
    if (wr) begin
      wr_lo_n = 1'b0; wr_hi_n = 1'b0;
    end else begin
      rd_lo_n = 1'b0; rd_hi_n = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1;
    got_oe = bus_stall_oe;
    @(negedge clk);
    release_bus();
    for (int n = 0; n < 3; n++) begin
      @(posedge clk); #1;
      if (bus_stall_oe && bus_stall_n) saw_hi = 1'b1;
    end
    released = !bus_stall_oe && !bus_dout_oe;
  endtask

  task automatic read_word(input logic [16:0] a, output logic [15:0] v);
    int o, h; bit dk, rl;
    run_access(1'b0, a, 16'h0, 2'b11, 1'b1, v, o, h, dk, rl);
  endtask

  initial begin
    logic [15:0] rv;
    int oe_at, hi_at;
    bit doe_ok, rel, got_oe, saw_hi;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    chk("R1", "wait enable after reset", 32'(bus_stall_oe), 32'd0);
    chk("R1", "data enable after reset", 32'(bus_dout_oe), 32'd0);
    chk("R1", "error count after reset", 32'(err_count), 32'd0);

    // vector table: R2 R3 R4 R5 R6 R9
    for (int i = 0; i < NV; i++) begin
      run_access(VEC[i].wr, VEC[i].addr, VEC[i].data, VEC[i].lanes, 1'b1,
                 rv, oe_at, hi_at, doe_ok, rel);
      chk("R2", $sformatf("vec %0d wait enable edge", i), 32'(oe_at), 32'd3);
      chk("R3", $sformatf("vec %0d wait high edge", i), 32'(hi_at), 32'(3 + LAT));
      chk("R5", $sformatf("vec %0d released", i), 32'(rel), 32'd1);
      if (!VEC[i].wr) begin
        chk("R4", $sformatf("vec %0d read data", i), 32'(rv), 32'(VEC[i].exp));
        chk("R9", $sformatf("vec %0d data enable at ready", i), 32'(doe_ok), 32'd1);
      end else begin
        chk("R6", $sformatf("vec %0d no data drive on write", i), 32'(doe_ok), 32'd1);
      end
    end

    // R7: chip select high, write ignored
    run_access(1'b1, 17'h10000, 16'h0BAD, 2'b11, 1'b0, rv, oe_at, hi_at, doe_ok, rel);
    chk("R7", "no response with cs high", 32'(oe_at), 32'd0);
    read_word(17'h10000, rv);
    chk("R7", "word unchanged after cs high write", 32'(rv), 32'h77A5);

    // R7: out of window, aliases word 1 in the low bits
    run_access(1'b1, 17'h00002, 16'hDEAD, 2'b11, 1'b1, rv, oe_at, hi_at, doe_ok, rel);
    chk("R7", "no response outside window", 32'(oe_at), 32'd0);
    read_word(17'h10002, rv);
    chk("R7", "word unchanged after outside write", 32'(rv), 32'h12CD);

    // R8: abandoned write
    run_abort(1'b1, 17'h10002, 16'h0000, got_oe, saw_hi, rel);
    chk("R8", "abort write started", 32'(got_oe), 32'd1);
    chk("R8", "abort write never ready", 32'(saw_hi), 32'd0);
    chk("R8", "abort write released", 32'(rel), 32'd1);
    chk("R8", "error count after write abort", 32'(err_count), 32'd1);
    read_word(17'h10002, rv);
    chk("R8", "word unchanged after abort", 32'(rv), 32'h12CD);

    // R8: abandoned read
    run_abort(1'b0, 17'h10000, 16'h0000, got_oe, saw_hi, rel);
    chk("R8", "abort read released", 32'(rel), 32'd1);
    chk("R8", "error count after read abort", 32'(err_count), 32'd2);

    // R1: reset clears the count
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1", "error count after second reset", 32'(err_count), 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule